// File: doc/BRIEF.md
# Guarded Configuration Register with Staged Unlock

This block guards a small configuration register held in nonvolatile storage. The register carries a two-bit watchdog period code and a three-bit block-protect code. Two volatile latches sit beside it: a write-enable latch and a register-write-enable latch. The stored bits change only after three accepted register writes in a row. The first write (02h) arms the write-enable latch. The second write (06h) arms the register-write-enable latch. The third write carries the new values, with bit 1 set and bit 2 clear. The nonvolatile storage is modelled as flops, followed by a busy window of a fixed number of cycles during which every write is refused.

Requests come from a serial-bus front end that is not part of this block. Each request is a single decoded write. It is either a register write, carrying one data byte and two frame flags, or an array write, carrying a byte address. Requests travel on a valid/ready channel. The block answers each accepted request with one acknowledge decision on a valid/ready response channel. The same block-protect code selects which array addresses are closed to writes. A write-protect pin, when high, blocks all writes.

Back-pressure follows two rules. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while an earlier response is still waiting, that is, `rsp_valid` is high and `rsp_ready` is low. A response appears on the cycle after its request is accepted, and it holds steady until it is taken.

Top module: `cfgreg_guard`

## Requirements
- R1: After reset, `cfg_value` is 60h (watchdog code 11, protect code 000), both latches are 0, `nv_busy` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: When the register-write-enable latch is 0, a register write of 02h sets the write-enable latch and is acknowledged. A register write of 00h clears the write-enable latch and is acknowledged. Neither write changes the stored bits or produces a commit pulse.
- R3: When the register-write-enable latch is 0, a register write of 06h sets the register-write-enable latch and is acknowledged, but only if the write-enable latch is 1. Otherwise it is refused and nothing changes. The register-write-enable latch is never 1 while the write-enable latch is 0.
- R4: When the register-write-enable latch is 1, a register write with bit 2 = 0 and bit 1 = 1 does the following. It stores data bits 6:5 as the watchdog code and data bits {0,4,3} as the protect code {BP2,BP1,BP0}. It clears the register-write-enable latch and is acknowledged. It raises `commit_pulse` for exactly one cycle and holds `nv_busy` high for BUSY_CYCLES cycles.
- R5: When the register-write-enable latch is 1, a register write with bit 2 = 1 and bit 1 = 1 is acknowledged and changes nothing. A write with bit 1 = 0 is refused and changes nothing.
- R6: When the register-write-enable latch is 0, any register byte other than 00h, 02h and 06h is refused. While the write-enable latch is 0, every array write is refused.
- R7: A register write flagged as multi-byte (`req_multi` = 1) is refused and changes nothing. So is one without a proper closing stop (`req_stop_ok` = 0). Array writes disregard both flags.
- R8: The protect code {BP2,BP1,BP0} closes these 9-bit addresses to writes: 000 none; 001 180h–1FFh; 010 100h–1FFh; 011 all addresses; 100 000h–00Fh; 101 000h–01Fh; 110 000h–03Fh; 111 000h–07Fh. An array write to an open address is acknowledged when the write-enable latch is 1.
- R9: An array write to a closed address is refused and clears the register-write-enable latch.
- R10: While `wp` is high at acceptance, every request is refused and changes no state.
- R11: While `nv_busy` is high at acceptance, every request is refused and changes no state.
- R12: `req_ready` equals `!rsp_valid || rsp_ready`. A response held back by `rsp_ready` = 0 keeps `rsp_valid` and `rsp_ack` steady.
- R13: `cfg_value` is laid out, from bit 7 down to bit 0, as 0, WD1, WD0, BP1, BP0, register-write-enable latch, write-enable latch, BP2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can accept a request |
| req_is_reg | input | 1 | 1 = register write, 0 = array write |
| req_data | input | 8 | Register data byte |
| req_addr | input | ADDR_W | Array byte address |
| req_stop_ok | input | 1 | The register write ended with a proper stop |
| req_multi | input | 1 | More than one data byte followed the register address |
| wp | input | 1 | Write-protect pin |
| rsp_valid | output | 1 | A response is present |
| rsp_ready | input | 1 | The consumer takes the response |
| rsp_ack | output | 1 | 1 = the request was accepted as a write |
| commit_pulse | output | 1 | One-cycle pulse when the stored bits are rewritten |
| nv_busy | output | 1 | The nonvolatile cycle is in progress |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-write-enable latch |
| cfg_value | output | 8 | Readable register image |

## Verification
The assertions check on every cycle the properties that hold in any state. A request accepted while busy, under write-protect or with a bad frame is never acknowledged, and the bad-frame cases change nothing. The stored bits move only together with a commit pulse. The register-write-enable latch never stands without the write-enable latch. A stalled response stays put. Only the bench scenarios can show the unlock sequences themselves: 02h-06h-02h clearing the bits, 02h-06h-06h keeping them, the exact address edges of each protect code, and a protected array write dropping the unlock.

// File: rtl/cfgg_pkg.sv
package cfgg_pkg;

  typedef struct packed {
    logic [1:0] wd;   // watchdog period code
    logic [2:0] bp;   // protect code {BP2,BP1,BP0}
  } nv_bits_t;

  localparam logic [7:0] CMD_ARM_WEL  = 8'h02;
  localparam logic [7:0] CMD_ARM_RWEL = 8'h06;
  localparam logic [7:0] CMD_DISARM   = 8'h00;

  function automatic logic [7:0] view_of(nv_bits_t nv, logic rwel_b, logic wel_b);
    return {1'b0, nv.wd, nv.bp[1], nv.bp[0], rwel_b, wel_b, nv.bp[2]};
  endfunction

  function automatic nv_bits_t nv_from_byte(logic [7:0] d);
    nv_bits_t r;
    r.wd = d[6:5];
    r.bp = {d[0], d[4], d[3]};
    return r;
  endfunction

endpackage

// File: rtl/cfgg_prot_map.sv
module cfgg_prot_map #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic [2:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int LOW_WINDOWS = 4;

  logic [LOW_WINDOWS-1:0] low_hit;

  for (genvar k = 0; k < LOW_WINDOWS; k++) begin : g_low
    assign low_hit[k] = (addr[ADDR_W-1:PAGE_W+k] == '0);
  end

  always_comb begin
    unique case (bp)
      3'b000:  hit = 1'b0;
      3'b001:  hit = &addr[ADDR_W-1:ADDR_W-2];
      3'b010:  hit = addr[ADDR_W-1];
      3'b011:  hit = 1'b1;
      default: hit = low_hit[bp[1:0]];
    endcase
  end
endmodule

// File: rtl/cfgg_busy_timer.sv
module cfgg_busy_timer #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R11
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/cfgg_unlock_ctl.sv
module cfgg_unlock_ctl
  import cfgg_pkg::*;
#(
  parameter logic [1:0] RST_WD = 2'b11,
  parameter logic [2:0] RST_BP = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       is_reg,
  input  logic [7:0] data,
  input  logic       prot_hit,
  input  logic       stop_ok,
  input  logic       multi,
  input  logic       wp,
  input  logic       busy,
  output logic       ack,
  output logic       commit,
  output logic       wel_q,
  output logic       rwel_q,
  output nv_bits_t   nv_q
);
  logic     wel_n, rwel_n;
  nv_bits_t nv_n;

  always_comb begin
    ack    = 1'b0;
    commit = 1'b0;
    wel_n  = wel_q;
    rwel_n = rwel_q;
    nv_n   = nv_q;
    if (!wp && !busy) begin
      if (!is_reg) begin
        if (prot_hit)   rwel_n = 1'b0;
        else if (wel_q) ack    = 1'b1;
      end else if (stop_ok && !multi) begin
        if (rwel_q) begin
          if (data[1]) begin
            ack = 1'b1;
            if (!data[2]) begin
              commit = 1'b1;
              rwel_n = 1'b0;
              nv_n   = nv_from_byte(data);
            end
          end
        end else begin
          unique case (data)
            CMD_ARM_WEL: begin
              wel_n = 1'b1;
              ack   = 1'b1;
            end
            CMD_ARM_RWEL: begin
              if (wel_q) begin
                rwel_n = 1'b1;
                ack    = 1'b1;
              end
            end
            CMD_DISARM: begin
              wel_n = 1'b0;
              ack   = 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
      nv_q   <= '{wd: RST_WD, bp: RST_BP};
    end else if (fire) begin
      wel_q  <= wel_n;
      rwel_q <= rwel_n;
      nv_q   <= nv_n;
    end
  end

  // R3
  rwel_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rwel_q |-> wel_q);
endmodule

// File: rtl/cfgreg_guard.sv
module cfgreg_guard
  import cfgg_pkg::*;
#(
  parameter int         ADDR_W      = 9,
  parameter int         PAGE_W      = 4,
  parameter int         BUSY_CYCLES = 64,
  parameter logic [1:0] RST_WD      = 2'b11,
  parameter logic [2:0] RST_BP      = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_reg,
  input  logic [7:0]        req_data,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_stop_ok,
  input  logic              req_multi,
  input  logic              wp,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ack,
  output logic              commit_pulse,
  output logic              nv_busy,
  output logic              wel,
  output logic              rwel,
  output logic [7:0]        cfg_value
);
  logic     fire, prot_hit, dec_ack, dec_commit;
  nv_bits_t nv;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  cfgg_prot_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
    .bp   (nv.bp),
    .addr (req_addr),
    .hit  (prot_hit)
  );

  cfgg_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fire && dec_commit),
    .busy  (nv_busy)
  );

  cfgg_unlock_ctl #(.RST_WD(RST_WD), .RST_BP(RST_BP)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .is_reg   (req_is_reg),
    .data     (req_data),
    .prot_hit (prot_hit),
    .stop_ok  (req_stop_ok),
    .multi    (req_multi),
    .wp       (wp),
    .busy     (nv_busy),
    .ack      (dec_ack),
    .commit   (dec_commit),
    .wel_q    (wel),
    .rwel_q   (rwel),
    .nv_q     (nv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_ack      <= 1'b0;
      commit_pulse <= 1'b0;
    end else begin
      commit_pulse <= fire && dec_commit;
      if (fire) begin
        rsp_valid <= 1'b1;
        rsp_ack   <= dec_ack;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign cfg_value = view_of(nv, rwel, wel);

  // R11
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && nv_busy) |=> (rsp_valid && !rsp_ack && $stable(cfg_value)));

  // R10
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wp) |=> (rsp_valid && !rsp_ack && $stable(cfg_value)));

  // R7
  frame_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_is_reg && (req_multi || !req_stop_ok)) |=> (!rsp_ack && $stable(cfg_value)));

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ack)));

  // R4
  commit_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (!rwel && nv_busy && rsp_ack));

  // R4
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);

  // R13
  nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |-> $stable({cfg_value[7:3], cfg_value[0]}));
endmodule

// File: tb/test_cfgreg_guard.sv
module test_cfgreg_guard;
  localparam int BUSY = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_is_reg = 1'b0, req_stop_ok = 1'b1, req_multi = 1'b0;
  logic       wp = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_data = '0;
  logic [8:0] req_addr = '0;
  logic       req_ready, rsp_valid, rsp_ack, commit_pulse, nv_busy, wel, rwel;
  logic [7:0] cfg_value;

  int checks = 0, errors = 0, edges = 0, last_commit = -1000;
  bit done = 0;

  bit       m_wel = 0, m_rwel = 0;
  bit [1:0] m_wd = 2'b11;
  bit [2:0] m_bp = 3'b000;

  always #10 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  cfgreg_guard #(.BUSY_CYCLES(BUSY)) i_cfgreg_guard (
    .clk, .rst_n, .req_valid, .req_ready, .req_is_reg, .req_data, .req_addr,
    .req_stop_ok, .req_multi, .wp, .rsp_valid, .rsp_ready, .rsp_ack,
    .commit_pulse, .nv_busy, .wel, .rwel, .cfg_value
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit prot_fn(input bit [2:0] bp, input bit [8:0] a);
    case (bp)
      3'b001:  return a >= 9'h180;
      3'b010:  return a >= 9'h100;
      3'b011:  return 1'b1;
      3'b100:  return a <= 9'h00F;
      3'b101:  return a <= 9'h01F;
      3'b110:  return a <= 9'h03F;
      3'b111:  return a <= 9'h07F;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit [7:0] m_view();
    return {1'b0, m_wd, m_bp[1], m_bp[0], m_rwel, m_wel, m_bp[2]};
  endfunction

  task automatic mdl_step(input bit is_reg, input bit [7:0] d, input bit [8:0] a,
                          input bit sok, input bit mul, input bit wpv, input bit bsy,
                          output bit ack, output bit cmt);
    ack = 0; cmt = 0;
    if (!wpv && !bsy) begin
      if (!is_reg) begin
        if (prot_fn(m_bp, a)) m_rwel = 0;
        else if (m_wel) ack = 1;
      end else if (sok && !mul) begin
        if (m_rwel) begin
          if (d[1]) begin
            ack = 1;
            if (!d[2]) begin
              cmt = 1; m_rwel = 0; m_wd = d[6:5]; m_bp = {d[0], d[4], d[3]};
            end
          end
        end else if (d == 8'h02) begin m_wel = 1; ack = 1; end
        else if (d == 8'h06) begin if (m_wel) begin m_rwel = 1; ack = 1; end end
        else if (d == 8'h00) begin m_wel = 0; ack = 1; end
      end
    end
  endtask

  task automatic send(input bit is_reg, input bit [7:0] d, input bit [8:0] a,
                      input bit sok, input bit mul, input bit wpv, input string rq);
    bit ea, ec, eb;
    @(negedge clk);
    req_is_reg = is_reg; req_data = d; req_addr = a;
    req_stop_ok = sok; req_multi = mul; wp = wpv; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R12", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0; wp = 1'b0;
    eb = (edges - last_commit) <= BUSY;
    mdl_step(is_reg, d, a, sok, mul, wpv, eb, ea, ec);
    if (ec) last_commit = edges;
    chk(rsp_valid == 1'b1, {rq, " rsp_valid"}, rsp_valid, 1);
    chk(rsp_ack == ea, {rq, " ack"}, rsp_ack, ea);
    chk(commit_pulse == ec, {rq, " commit"}, commit_pulse, ec);
    chk(cfg_value == m_view(), {rq, " cfg_value"}, cfg_value, m_view());
  endtask

  task automatic wait_idle();
    repeat (BUSY + 2) @(negedge clk);
    chk(nv_busy == 1'b0, "R11 busy ends", nv_busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_value == 8'h60, "R1 cfg_value", cfg_value, 8'h60);
    chk(!wel && !rwel, "R1 latches", {wel, rwel}, 0);
    chk(!nv_busy && !rsp_valid && req_ready, "R1 flags", {nv_busy, rsp_valid, req_ready}, 1);

    send(1, 8'h06, 0, 1, 0, 0, "R3 06h without WEL");
    send(0, 9'h000, 9'h000, 1, 0, 0, "R6 array without WEL");
    send(1, 8'h07, 0, 1, 0, 0, "R6 odd byte");
    send(1, 8'h02, 0, 1, 0, 0, "R2 arm WEL");
    chk(wel == 1'b1, "R2 wel port", wel, 1);
    send(1, 8'h00, 0, 1, 0, 0, "R2 disarm");
    send(1, 8'h02, 0, 1, 0, 0, "R2 rearm");
    send(1, 8'h06, 0, 1, 0, 0, "R3 arm RWEL");
    chk(rwel == 1'b1, "R3 rwel port", rwel, 1);
    send(1, 8'h06, 0, 1, 0, 0, "R5 06h keeps bits");
    send(1, 8'h00, 0, 1, 0, 0, "R5 bit1 clear refused");
    send(1, 8'h0A, 0, 1, 1, 0, "R7 multi byte");
    send(1, 8'h0A, 0, 0, 0, 0, "R7 no stop");
    send(1, 8'h0A, 0, 1, 0, 1, "R10 wp");
    send(1, 8'h0A, 0, 1, 0, 0, "R4 commit 0Ah");
    chk(cfg_value == 8'h0A, "R13 layout 0Ah", cfg_value, 8'h0A);
    @(negedge clk);
    chk(commit_pulse == 1'b0 && nv_busy == 1'b1, "R4 single pulse busy", {commit_pulse, nv_busy}, 1);
    send(1, 8'h02, 0, 1, 0, 0, "R11 busy reg");
    send(0, 8'h00, 9'h010, 1, 0, 0, "R11 busy array");
    wait_idle();
    send(0, 8'h00, 9'h17F, 1, 0, 0, "R8 17F open");
    send(0, 8'h00, 9'h180, 1, 0, 0, "R8 180 closed");
    send(1, 8'h06, 0, 1, 0, 0, "R3 arm RWEL again");
    send(0, 8'h00, 9'h1FF, 1, 0, 0, "R9 protected clears RWEL");
    chk(rwel == 1'b0, "R9 rwel port", rwel, 0);
    send(1, 8'h06, 0, 1, 0, 0, "R3 arm RWEL");
    send(1, 8'h73, 0, 1, 0, 0, "R4 commit 73h");
    chk(cfg_value == 8'h73, "R13 layout 73h", cfg_value, 8'h73);
    wait_idle();
    send(0, 8'h00, 9'h03F, 1, 0, 0, "R8 03F closed");
    send(0, 8'h00, 9'h040, 1, 0, 0, "R8 040 open");
    send(1, 8'h06, 0, 1, 0, 0, "R3 arm");
    send(1, 8'h02, 0, 1, 0, 0, "R4 02h clears bits");
    chk(cfg_value == 8'h02, "R4 cleared", cfg_value, 8'h02);
    wait_idle();

    // R12 stalled response
    @(negedge clk); @(negedge clk);
    rsp_ready = 1'b0;
    send(1, 8'h02, 0, 1, 0, 0, "R12 stalled send");
    chk(req_ready == 1'b0, "R12 ready low", req_ready, 0);
    repeat (2) @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_ack == 1'b1, "R12 held", {rsp_valid, rsp_ack}, 3);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12 released", rsp_valid, 0);

    for (int n = 0; n < 400; n++) begin
      int r;
      bit [7:0] d;
      bit isr;
      r = $urandom_range(0, 99);
      if (r < 30)      d = 8'h02;
      else if (r < 55) d = 8'h06;
      else if (r < 80) d = (8'($urandom()) & 8'hF9) | 8'h02;
      else if (r < 90) d = 8'h00;
      else             d = 8'($urandom());
      isr = ($urandom_range(0, 99) < 70);
      send(isr, d, 9'($urandom()), $urandom_range(0, 99) >= 5,
           $urandom_range(0, 99) < 5, $urandom_range(0, 99) < 5, "R8 random");
      if ($urandom_range(0, 19) == 0) repeat (BUSY) @(negedge clk);
      else repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule